// File: doc/BRIEF.md
# Dual CPU bus switch

This block lets two processor cores share one 16-bit memory bus, with exactly one of them owning it at any moment. Each core presents a valid/ready memory request port (address, write data, write enable) and receives read data. The owning core's request is steered straight through to the shared bus. The other core sees ready held low, so it is stalled and issues no bus cycle. A one-bit ownership flag decides which core is the owner.

Software flips ownership by writing to a mode-switch window in the shared address space. A completed write there with data bit 0 clear hands the bus to the secondary core. With bit 0 set, it hands the bus back to the primary core. Every address from the secondary core is shifted up by a fixed offset before it reaches the bus. This moves the secondary core's reset vector away from the primary core's low-memory I/O registers. The window is decoded on the shifted address as it appears on the bus.

Back-pressure rules are as follows. A request transfers in the cycle where valid and ready are both high. A core must hold its address, data and write enable stable while its valid is high and ready is low. For a read, the read data returned to the owner is valid in the transfer cycle. The shared bus follows the same rules, with the memory side driving bus_ready and bus_rdata.

Top module: `cpu_bus_switch`

## Requirements
- R1: After reset the primary core owns the bus, and active_core reads 0.
- R2: The owner's valid, write enable and write data appear unchanged on bus_valid, bus_we and bus_wdata in the same cycle. The owner's ready equals bus_ready.
- R3: The non-owner's ready is held at 0, and its request never raises bus_valid.
- R4: A secondary-core address reaches bus_addr with 0x1000 added, truncated to 16 bits: 0xF000 becomes 0x0000 and 0xFFFF becomes 0x0FFF. A primary-core address passes unchanged.
- R5: A completed write (bus_valid, bus_ready and bus_we all high) to a bus address from 0xDE00 to 0xDEFF makes the secondary core the owner from the next cycle if data bit 0 is 0. It makes the primary core the owner if data bit 0 is 1. If the named core already owns the bus, ownership does not change.
- R6: A read of the window does not change ownership, and neither does a window write that is held off by bus_ready low.
- R7: Writes just outside the window, to bus addresses 0xDDFF and 0xDF00, do not change ownership. A secondary-core write whose core-side address is 0xDE00 lands at bus address 0xEE00 and is not a command.
- R8: The mode-switch write itself is forwarded to the bus and completes for the core that issued it. The new owner can transfer in the following cycle.
- R9: bus_rdata is routed to the owner's read data port. The non-owner's read data is 0.
- R10: active_core is 0 while the primary core owns the bus and 1 while the secondary core owns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_valid | input | 1 | Primary core request valid |
| pri_ready | output | 1 | Primary core request accepted |
| pri_addr | input | 16 | Primary core address |
| pri_wdata | input | 8 | Primary core write data |
| pri_we | input | 1 | Primary core write enable |
| pri_rdata | output | 8 | Read data to primary core |
| sec_valid | input | 1 | Secondary core request valid |
| sec_ready | output | 1 | Secondary core request accepted |
| sec_addr | input | 16 | Secondary core address, before offset |
| sec_wdata | input | 8 | Secondary core write data |
| sec_we | input | 1 | Secondary core write enable |
| sec_rdata | output | 8 | Read data to secondary core |
| bus_valid | output | 1 | Shared bus request valid |
| bus_ready | input | 1 | Shared bus accepts request |
| bus_addr | output | 16 | Shared bus address |
| bus_wdata | output | 8 | Shared bus write data |
| bus_we | output | 1 | Shared bus write enable |
| bus_rdata | input | 8 | Shared bus read data |
| active_core | output | 1 | 0 primary owns, 1 secondary owns |

## Verification
A wrong ownership flag is visible at the ports in the same cycle it exists. The wrong core gets ready, the bus address comes from the wrong source, with or without the offset, and active_core disagrees with the last command. A command that fails to take effect, or that takes effect when it should not, shows up one cycle after the write transfer. The bench therefore checks ownership one edge after every stimulus vector, including window boundaries, stalled writes and reads of the window. Offset errors show up directly on bus_addr during the wraparound cases.

// File: rtl/cbsw_pkg.sv
package cbsw_pkg;
  typedef enum logic {
    OWN_PRI = 1'b0,
    OWN_SEC = 1'b1
  } owner_e;
endpackage

// File: rtl/cbsw_addr_offset.sv
module cbsw_addr_offset #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFFSET = 'h1000
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] OFF_V = ADDR_W'(OFFSET);

  generate
    if (OFFSET == 0) begin : g_pass
      assign addr_out = addr_in;
    end else begin : g_add
      // sum wraps at the address width
      assign addr_out = addr_in + OFF_V;
    end
  endgenerate
endmodule

// File: rtl/cbsw_switch_decode.sv
module cbsw_switch_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_LO = 'hDE00,
  parameter int unsigned WIN_HI = 'hDEFF
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              xfer,
  input  logic              sel_bit,
  output logic              cmd_fire,
  output logic              cmd_release
);
  localparam logic [ADDR_W-1:0] LO_V = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] HI_V = ADDR_W'(WIN_HI);

  logic in_win;
  assign in_win      = (bus_addr >= LO_V) && (bus_addr <= HI_V);
  assign cmd_fire    = xfer && bus_we && in_win;
  assign cmd_release = sel_bit;
endmodule

// File: rtl/cbsw_owner_flag.sv
module cbsw_owner_flag
  import cbsw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_fire,
  input  logic   cmd_release,
  output owner_e owner
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= OWN_PRI;
    end else if (cmd_fire) begin
      owner <= cmd_release ? OWN_PRI : OWN_SEC;
    end
  end

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |=> $stable(owner));

  // R5
  flag_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !cmd_release) |=> (owner == OWN_SEC));

  // R5
  flag_give_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_release) |=> (owner == OWN_PRI));
endmodule

// File: rtl/cpu_bus_switch.sv
module cpu_bus_switch
  import cbsw_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OFFSET  = 'h1000,
  parameter int unsigned WIN_LO  = 'hDE00,
  parameter int unsigned WIN_HI  = 'hDEFF,
  parameter int unsigned SEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_valid,
  output logic              pri_ready,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic [DATA_W-1:0] pri_wdata,
  input  logic              pri_we,
  output logic [DATA_W-1:0] pri_rdata,
  input  logic              sec_valid,
  output logic              sec_ready,
  input  logic [ADDR_W-1:0] sec_addr,
  input  logic [DATA_W-1:0] sec_wdata,
  input  logic              sec_we,
  output logic [DATA_W-1:0] sec_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              active_core
);
  localparam logic [ADDR_W-1:0] OFF_V = ADDR_W'(OFFSET);

  owner_e            owner;
  logic              sec_own;
  logic [ADDR_W-1:0] sec_bus_addr;
  logic              xfer;
  logic              cmd_fire;
  logic              cmd_release;

  assign sec_own = (owner == OWN_SEC);

  cbsw_addr_offset #(
    .ADDR_W (ADDR_W),
    .OFFSET (OFFSET)
  ) offset_i (
    .addr_in  (sec_addr),
    .addr_out (sec_bus_addr)
  );

  // request steering: only the owner reaches the bus
  always_comb begin
    if (sec_own) begin
      bus_valid = sec_valid;
      bus_addr  = sec_bus_addr;
      bus_wdata = sec_wdata;
      bus_we    = sec_we;
    end else begin
      bus_valid = pri_valid;
      bus_addr  = pri_addr;
      bus_wdata = pri_wdata;
      bus_we    = pri_we;
    end
  end

  assign pri_ready = !sec_own && bus_ready;
  assign sec_ready =  sec_own && bus_ready;
  assign pri_rdata = sec_own ? '0 : bus_rdata;
  assign sec_rdata = sec_own ? bus_rdata : '0;
  assign xfer      = bus_valid && bus_ready;

  cbsw_switch_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI)
  ) decode_i (
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .xfer        (xfer),
    .sel_bit     (bus_wdata[SEL_BIT]),
    .cmd_fire    (cmd_fire),
    .cmd_release (cmd_release)
  );

  cbsw_owner_flag owner_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .cmd_release (cmd_release),
    .owner       (owner)
  );

  assign active_core = sec_own;

  // R3
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_ready && sec_ready));

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_valid && !sec_valid) |-> !bus_valid);

  // R4
  sec_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_ready && bus_valid) |-> ((bus_addr - sec_addr) == OFF_V));

  // R9
  nonowner_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_core ? pri_rdata : sec_rdata) == '0);
endmodule

// File: tb/cpu_bus_switch_tb_top.sv
module cpu_bus_switch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pri_valid = 1'b0, pri_we = 1'b0;
  logic [15:0] pri_addr = '0;
  logic [7:0]  pri_wdata = '0;
  logic        sec_valid = 1'b0, sec_we = 1'b0;
  logic [15:0] sec_addr = '0;
  logic [7:0]  sec_wdata = '0;
  logic        bus_ready = 1'b0;
  logic [7:0]  bus_rdata = '0;
  logic        pri_ready, sec_ready, bus_valid, bus_we, active_core;
  logic [7:0]  pri_rdata, sec_rdata, bus_wdata;
  logic [15:0] bus_addr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cpu_bus_switch dut_i (
    .clk(clk), .rst_n(rst_n),
    .pri_valid(pri_valid), .pri_ready(pri_ready), .pri_addr(pri_addr),
    .pri_wdata(pri_wdata), .pri_we(pri_we), .pri_rdata(pri_rdata),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_addr(sec_addr),
    .sec_wdata(sec_wdata), .sec_we(sec_we), .sec_rdata(sec_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .active_core(active_core)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        pv, sv, we, br;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic        ebv;
    logic [15:0] eaddr;
    logic        epr, esr, eact;
  } vec_t;

  localparam int NV = 16;
  // pv sv we br addr wd | bus_valid bus_addr pri_ready sec_ready active_after
  localparam logic [47:0] VEC [NV] = '{
    {4'b1001, 16'h0001, 8'h00, 1'b1, 16'h0001, 3'b100}, // R2 primary read
    {4'b0101, 16'h0000, 8'h00, 1'b0, 16'h0000, 3'b100}, // R3 secondary stalled
    {4'b1011, 16'hDE00, 8'h01, 1'b1, 16'hDE00, 3'b100}, // R5 release while primary owns
    {4'b1011, 16'hDDFF, 8'h00, 1'b1, 16'hDDFF, 3'b100}, // R7 below window
    {4'b1011, 16'hDF00, 8'h00, 1'b1, 16'hDF00, 3'b100}, // R7 above window
    {4'b1001, 16'hDE10, 8'h00, 1'b1, 16'hDE10, 3'b100}, // R6 window read
    {4'b1010, 16'hDE80, 8'h00, 1'b1, 16'hDE80, 3'b000}, // R6 stalled window write
    {4'b1011, 16'hDE80, 8'h00, 1'b1, 16'hDE80, 3'b101}, // R5 R8 hand to secondary
    {4'b1001, 16'h1234, 8'h00, 1'b0, 16'h0000, 3'b011}, // R3 primary stalled
    {4'b0101, 16'h0000, 8'h00, 1'b1, 16'h1000, 3'b011}, // R4 offset
    {4'b0101, 16'hF000, 8'h00, 1'b1, 16'h0000, 3'b011}, // R4 wrap
    {4'b0101, 16'hFFFF, 8'h00, 1'b1, 16'h0FFF, 3'b011}, // R4 wrap top
    {4'b0111, 16'hCEFF, 8'h00, 1'b1, 16'hDEFF, 3'b011}, // R5 take while secondary owns
    {4'b0111, 16'hDE00, 8'h01, 1'b1, 16'hEE00, 3'b011}, // R7 core-side window not a command
    {4'b0111, 16'hCE42, 8'h03, 1'b1, 16'hDE42, 3'b010}, // R5 R8 hand back
    {4'b1001, 16'h0002, 8'h00, 1'b1, 16'h0002, 3'b100}  // R8 primary resumes
  };

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    #1;
    check(active_core == 1'b0, "R1 reset owner", active_core, 0);
    check(bus_valid == 1'b0, "R1 reset bus idle", bus_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      v = VEC[i];
      pri_valid = v.pv; sec_valid = v.sv; bus_ready = v.br;
      pri_addr = v.addr; sec_addr = v.addr;
      pri_wdata = v.wd; sec_wdata = v.wd;
      pri_we = v.we; sec_we = v.we;
      #1;
      check(bus_valid == v.ebv, "R2 R3 bus_valid", bus_valid, v.ebv);
      check(pri_ready == v.epr, "R3 pri_ready", pri_ready, v.epr);
      check(sec_ready == v.esr, "R3 sec_ready", sec_ready, v.esr);
      if (v.ebv) begin
        check(bus_addr == v.eaddr, "R4 bus_addr", bus_addr, v.eaddr);
        check(bus_we == v.we, "R2 bus_we", bus_we, v.we);
        check(bus_wdata == v.wd, "R2 bus_wdata", bus_wdata, v.wd);
      end
      @(posedge clk);
      #1;
      check(active_core == v.eact, "R5 R10 active_core", active_core, v.eact);
    end

    // R9: read data routing while primary owns
    @(negedge clk);
    pri_valid = 1'b1; sec_valid = 1'b1; pri_we = 1'b0; sec_we = 1'b0;
    bus_ready = 1'b1; bus_rdata = 8'hA5;
    #1;
    check(pri_rdata == 8'hA5, "R9 owner rdata", pri_rdata, 8'hA5);
    check(sec_rdata == 8'h00, "R9 non-owner rdata", sec_rdata, 0);

    // hand to secondary, then check routing flips and reset restores R1
    @(negedge clk);
    pri_we = 1'b1; pri_addr = 16'hDEFF; pri_wdata = 8'hFE;
    @(posedge clk);
    #1;
    check(active_core == 1'b1, "R5 window top", active_core, 1);
    @(negedge clk);
    pri_we = 1'b0; bus_rdata = 8'h3C;
    #1;
    check(sec_rdata == 8'h3C, "R9 secondary rdata", sec_rdata, 8'h3C);
    check(pri_rdata == 8'h00, "R9 primary blanked", pri_rdata, 0);
    rst_n = 1'b0;
    #1;
    check(active_core == 1'b0, "R1 reset mid-run", active_core, 0);
    check(pri_ready == 1'b1, "R1 primary ready after reset", pri_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule